// File: doc/BRIEF.md
# Next Program Counter Generator

This block holds the program counter of a 32-bit load/store core and works out, every cycle, the address of the next instruction to fetch. A two-bit selector picks one of four sources. The first is straight-line fetch at PC + 4. The second is a PC-relative conditional branch, steered by a taken input that a compare unit elsewhere supplies. The third is a jump that stays inside the current 256 MB region and takes its low bits from a 26-bit instruction field. The fourth is a jump to any 32-bit address held in a register operand.

The candidate next address appears combinationally on `next_pc_o`. The PC register loads it on the rising clock edge whenever `stall_i` is low. A register jump whose target is not a multiple of 4 raises `misalign_o` in the same cycle. The address itself is passed through untouched, so the exception logic downstream sees the exact offending value.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, until the first enabled edge, `pc_o` equals the parameter `RESET_VEC` (default 0x0000_1000).
- R2: With `sel_i` = 0 (sequential), `next_pc_o` = `pc_o` + 4.
- R3: With `sel_i` = 1 (branch) and `taken_i` high, `next_pc_o` = `pc_o` + 4 + (sign-extended 16-bit `imm_i` shifted left by 2).
- R4: With `sel_i` = 1 and `taken_i` low, `next_pc_o` = `pc_o` + 4.
- R5: With `sel_i` = 2 (region jump), `next_pc_o` = {bits 31:28 of (`pc_o` + 4), `jidx_i`[25:0], 2'b00}.
- R6: With `sel_i` = 3 (register jump), `next_pc_o` equals `reg_i` bit for bit.
- R7: `misalign_o` is high exactly when `sel_i` = 3 and `reg_i`[1:0] is nonzero. It never alters `next_pc_o`.
- R8: While `stall_i` is high, `pc_o` keeps its value across clock edges.
- R9: All address arithmetic wraps modulo 2^32.
- R10: On a rising edge with `stall_i` low and reset released, `pc_o` takes the value that `next_pc_o` had before the edge.
- R11: The region of a region jump comes from `pc_o` + 4 and not from `pc_o`, so a jump in the last word of a region lands in the following region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Holds the PC register when high |
| sel_i | input | 2 | Source: 0 sequential, 1 branch, 2 region jump, 3 register jump |
| taken_i | input | 1 | Branch condition result |
| imm_i | input | 16 | Signed branch word offset |
| jidx_i | input | 26 | Region jump word index |
| reg_i | input | 32 | Register jump target |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Computed next program counter |
| misalign_o | output | 1 | Register jump target not word aligned |

## Verification
The assertions watch the PC register every cycle. They check that a stall freezes it, that an enabled edge copies in the candidate address, that a fall-through branch gives PC + 4, that an aligned PC always yields an aligned candidate outside register jumps, and that the misalignment flag is raised only for register jumps. The exact arithmetic needs the directed scenarios in the bench: negative and extreme branch offsets, wrap past the top of the address space, and the region boundary that comes from PC + 4. The same holds for the bit-exact pass-through of a misaligned register target and the reset value.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ     = 2'd0,
    NPC_BRANCH  = 2'd1,
    NPC_JREGION = 2'd2,
    NPC_JREG    = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_rel_adder.sv
module npc_rel_adder #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o
);
  localparam int EXT_W = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] offset;

  // word offset -> byte offset, sign-extended
  assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign seq_o  = pc_i + STEP;
  assign br_o   = seq_o + offset;
endmodule

// File: rtl/npc_region_jump.sv
module npc_region_jump #(
  parameter int XLEN   = 32,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   seq_i,
  input  logic [JIDX_W-1:0] jidx_i,
  output logic [XLEN-1:0]   tgt_o
);
  localparam int REGION_W = XLEN - JIDX_W - 2;

  // region bits come from the incremented PC
  assign tgt_o = {seq_i[XLEN-1 -: REGION_W], jidx_i, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  npc_sel_e        sel_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_i,
  input  logic [XLEN-1:0] region_i,
  input  logic [XLEN-1:0] reg_i,
  output logic [XLEN-1:0] next_o,
  output logic            misalign_o
);
  always_comb begin
    unique case (sel_i)
      NPC_BRANCH:  next_o = taken_i ? br_i : seq_i;
      NPC_JREGION: next_o = region_i;
      NPC_JREG:    next_o = reg_i;
      default:     next_o = seq_i;
    endcase
  end

  // flag only; target passed through unchanged
  assign misalign_o = (sel_i == NPC_JREG) && (reg_i[1:0] != 2'b00);
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import npc_pkg::*;
#(
  parameter int               XLEN      = 32,
  parameter int               IMM_W     = 16,
  parameter int               JIDX_W    = 26,
  parameter logic [XLEN-1:0]  RESET_VEC = 32'h0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [1:0]        sel_i,
  input  logic              taken_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [JIDX_W-1:0] jidx_i,
  input  logic [XLEN-1:0]   reg_i,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              misalign_o
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] region_pc;
  npc_sel_e        sel;

  assign sel = npc_sel_e'(sel_i);

  npc_rel_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) u_adder (
    .pc_i  (pc_q),
    .imm_i (imm_i),
    .seq_o (seq_pc),
    .br_o  (br_pc)
  );

  npc_region_jump #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_region (
    .seq_i  (seq_pc),
    .jidx_i (jidx_i),
    .tgt_o  (region_pc)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .sel_i      (sel),
    .taken_i    (taken_i),
    .seq_i      (seq_pc),
    .br_i       (br_pc),
    .region_i   (region_pc),
    .reg_i      (reg_i),
    .next_o     (next_pc_o),
    .misalign_o (misalign_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= RESET_VEC;
    else if (!stall_i) pc_q <= next_pc_o;
  end

  assign pc_o = pc_q;

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pc_o)); // R8
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> pc_o == $past(next_pc_o)); // R10
  AST_FALL_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd1 && !taken_i) |-> next_pc_o == pc_o + XLEN'(4)); // R4
  AST_ALIGN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != 2'd3 && pc_o[1:0] == 2'b00) |-> next_pc_o[1:0] == 2'b00); // R2
  AST_MISALIGN_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (sel_i == 2'd3 && reg_i[1:0] != 2'b00)); // R7
endmodule

// File: tb/sim_pc_next_unit.sv
module sim_pc_next_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stall_i = 1'b1;
  logic [1:0]  sel_i = 2'd0;
  logic        taken_i = 1'b0;
  logic [15:0] imm_i = '0;
  logic [25:0] jidx_i = '0;
  logic [31:0] reg_i = '0;
  logic [31:0] pc_o, next_pc_o;
  logic        misalign_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pc_next_unit #(.RESET_VEC(RVEC)) u0 (
    .clk_i, .rst_ni, .stall_i, .sel_i, .taken_i, .imm_i, .jidx_i, .reg_i,
    .pc_o, .next_pc_o, .misalign_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // load pc through a register jump
  task automatic load_pc(input logic [31:0] v);
    @(negedge clk_i);
    sel_i = 2'd3; reg_i = v; stall_i = 1'b0;
    @(posedge clk_i); #1;
    stall_i = 1'b1; sel_i = 2'd0;
    chk("R10 load", pc_o, v);
  endtask

  task automatic drive(input logic [1:0] s, input logic t, input logic [15:0] im,
                       input logic [25:0] j, input logic [31:0] r);
    @(negedge clk_i);
    sel_i = s; taken_i = t; imm_i = im; jidx_i = j; reg_i = r;
    #1;
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2);
    chk("R1 in reset", pc_o, RVEC);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1 after release", pc_o, RVEC);
  endtask

  task automatic t_seq;
    drive(2'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    chk("R2 seq", next_pc_o, RVEC + 32'd4);
    stall_i = 1'b0;
    @(posedge clk_i); #1;
    stall_i = 1'b1;
    chk("R10 advance", pc_o, RVEC + 32'd4);
  endtask

  task automatic t_branch;
    load_pc(32'h0000_2000);
    drive(2'd1, 1'b1, 16'h0010, 26'h0, 32'h0);
    chk("R3 forward", next_pc_o, 32'h0000_2044);
    drive(2'd1, 1'b1, 16'hFFFF, 26'h0, 32'h0);
    chk("R3 back one", next_pc_o, 32'h0000_2000);
    drive(2'd1, 1'b1, 16'h8000, 26'h0, 32'h0);
    chk("R9 branch wrap", next_pc_o, 32'hFFFE_2004);
    drive(2'd1, 1'b0, 16'h0010, 26'h0, 32'h0);
    chk("R4 not taken", next_pc_o, 32'h0000_2004);
  endtask

  task automatic t_region;
    load_pc(32'h3000_0000);
    drive(2'd2, 1'b0, 16'h0, 26'h3FF_FFFF, 32'h0);
    chk("R5 region top", next_pc_o, 32'h3FFF_FFFC);
    drive(2'd2, 1'b0, 16'h0, 26'h000_0010, 32'h0);
    chk("R5 region low", next_pc_o, 32'h3000_0040);
    load_pc(32'h0FFF_FFFC);
    drive(2'd2, 1'b0, 16'h0, 26'h000_0010, 32'h0);
    chk("R11 region from pc+4", next_pc_o, 32'h1000_0040);
  endtask

  task automatic t_regjump;
    drive(2'd3, 1'b0, 16'h0, 26'h0, 32'h1234_5678);
    chk("R6 reg target", next_pc_o, 32'h1234_5678);
    chk("R7 aligned no flag", {31'b0, misalign_o}, 32'd0);
    drive(2'd3, 1'b0, 16'h0, 26'h0, 32'h0000_0ABE);
    chk("R7 flag", {31'b0, misalign_o}, 32'd1);
    chk("R7 value kept", next_pc_o, 32'h0000_0ABE);
    drive(2'd0, 1'b0, 16'h0, 26'h0, 32'h0000_0003);
    chk("R7 no flag off jreg", {31'b0, misalign_o}, 32'd0);
  endtask

  task automatic t_wrap;
    load_pc(32'hFFFF_FFFC);
    drive(2'd0, 1'b0, 16'h0, 26'h0, 32'h0);
    chk("R9 seq wrap", next_pc_o, 32'h0000_0000);
  endtask

  task automatic t_stall;
    logic [31:0] held;
    held = pc_o;
    drive(2'd3, 1'b0, 16'h0, 26'h0, 32'h0000_8000);
    stall_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_i); #1;
      chk("R8 stall hold", pc_o, held);
    end
  endtask

  initial begin
    t_reset();
    t_seq();
    t_branch();
    t_region();
    t_regjump();
    t_wrap();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule